// File: doc/BRIEF.md
# CAN Error Counter and Status Unit

This block holds the two fault-confinement counters of a CAN node, one for transmit faults and one for receive faults, and turns their levels into status flags and a single error interrupt. The bit-stream logic of the controller feeds it one-cycle event pulses. On the transmit side these are an acknowledge fault, a form fault, a bit fault and a successful transmission. On the receive side they are a receive fault, a successful reception, a receive overrun and an invalid message. Software reads the counters and flags, enables the interrupt, and clears the sticky flags by writing ones to a clear vector.

Each counter feeds a three-state level machine with the states LV_OK, LV_WARN and LV_PASS. The next state is the level of the counter's next value. The named transitions are: OK_TO_WARN, OK_TO_PASS, WARN_TO_PASS, WARN_TO_OK, PASS_TO_WARN and PASS_TO_OK. Any upward transition (OK_TO_WARN, OK_TO_PASS, WARN_TO_PASS) is an error cause. So are an overrun pulse and an invalid-message pulse. Every error cause sets the common error flag, and software uses the individual cause bits to tell the causes apart. The transmit warning level starts above 96. The receive warning level starts at 96. Both passive levels start above 127.

Top module: `can_errstat`

## Requirements
- R1: After reset both counters read 0, and all flags and the interrupt output read 0.
- R2: Each pulse on tx_ack_err_i, tx_form_err_i or tx_bit_err_i adds one to tx_cnt_o. Pulses in the same cycle add their number, and each rx_err_i pulse adds one to rx_cnt_o. The new value shows on the first clock edge after the pulse.
- R3: A tx_done_i or rx_done_i pulse subtracts one from its counter. A counter at 0 stays at 0, and a counter at 255 stays at 255 on further faults.
- R4: tx_warn_o is 1 exactly while tx_cnt_o is greater than 96.
- R5: rx_warn_o is 1 exactly while rx_cnt_o is 96 or more.
- R6: tx_pass_o is 1 exactly while tx_cnt_o is greater than 127. rx_pass_o is 1 exactly while rx_cnt_o is greater than 127.
- R7: An rx_ovr_i pulse sets ovr_flag_o and an rx_bad_i pulse sets bad_flag_o. Each stays set until a write of 1 to its clear bit: flag_clr_i[1] clears ovr_flag_o and flag_clr_i[2] clears bad_flag_o.
- R8: err_flag_o is set when either counter moves up into the warning or passive level, and on any rx_ovr_i or rx_bad_i pulse. It stays set until a write of 1 to flag_clr_i[0]. A set in the same cycle wins over the clear.
- R9: irq_o equals err_flag_o AND irq_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_ack_err_i | input | 1 | Transmit acknowledge fault pulse |
| tx_form_err_i | input | 1 | Transmit form fault pulse |
| tx_bit_err_i | input | 1 | Transmit bit fault pulse |
| tx_done_i | input | 1 | Successful transmission pulse |
| rx_err_i | input | 1 | Receive fault pulse |
| rx_done_i | input | 1 | Successful reception pulse |
| rx_ovr_i | input | 1 | Receive overrun pulse |
| rx_bad_i | input | 1 | Invalid message pulse |
| irq_en_i | input | 1 | Error interrupt enable |
| flag_clr_i | input | 3 | Write-1-to-clear: bit0 common, bit1 overrun, bit2 invalid |
| tx_cnt_o | output | 8 | Transmit error count |
| rx_cnt_o | output | 8 | Receive error count |
| tx_warn_o | output | 1 | Transmit warning level |
| tx_pass_o | output | 1 | Transmit passive level |
| rx_warn_o | output | 1 | Receive warning level |
| rx_pass_o | output | 1 | Receive passive level |
| ovr_flag_o | output | 1 | Sticky overrun cause bit |
| bad_flag_o | output | 1 | Sticky invalid-message cause bit |
| err_flag_o | output | 1 | Sticky common error flag |
| irq_o | output | 1 | Error interrupt |

## Verification
The bench builds the block with its default parameters: 8-bit counters, a warning threshold of 96 and a passive threshold of 127. With these values, a few hundred single-cycle pulses drive each counter across both thresholds in each direction, up to the 255 ceiling and down to the 0 floor. The bench can therefore probe the one-count difference between the transmit and receive warning levels, as well as every upward and downward level transition. Triple simultaneous transmit faults step the counter across the warning edge in one cycle, and clear-versus-set collisions probe the sticky flags.

// File: rtl/can_errstat_pkg.sv
package can_errstat_pkg;

    typedef enum logic [1:0] {
        LV_OK   = 2'd0,
        LV_WARN = 2'd1,
        LV_PASS = 2'd2
    } lvl_e;

    typedef enum logic [2:0] {
        TR_HOLD,
        TR_OK_TO_WARN,
        TR_OK_TO_PASS,
        TR_WARN_TO_PASS,
        TR_WARN_TO_OK,
        TR_PASS_TO_WARN,
        TR_PASS_TO_OK
    } lvl_tr_e;

endpackage

// File: rtl/errcnt_core.sv
module errcnt_core #(
    parameter int CNT_W = 8,
    parameter int INC_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [INC_W-1:0] inc_i,
    input  logic             dec_i,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d
);
    localparam int SUM_W = CNT_W + INC_W + 1;
    localparam logic [SUM_W-1:0] SUM_MAX = {{(INC_W+1){1'b0}}, {CNT_W{1'b1}}};
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [SUM_W-1:0] sum;

    always_comb begin
        sum = {{(INC_W+1){1'b0}}, cnt_q} + {{(CNT_W+1){1'b0}}, inc_i};
        if (dec_i && (sum != '0)) begin
            sum = sum - 1'b1;
        end
        if (sum > SUM_MAX) begin
            cnt_d = CNT_MAX;
        end else begin
            cnt_d = sum[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    a_r3_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && inc_i == '0) |=> (cnt_q == '0));
    a_r3_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !dec_i) |=> (cnt_q == CNT_MAX));
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i == '0 && !dec_i) |=> $stable(cnt_q));

endmodule

// File: rtl/errlvl_fsm.sv
module errlvl_fsm
    import can_errstat_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int WARN_LVL  = 96,
    parameter int PASS_LVL  = 127,
    parameter bit WARN_INCL = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] cnt_d,
    output logic             warn_o,
    output logic             pass_o,
    output logic             rise_o
);
    localparam int WARN_MIN = WARN_INCL ? WARN_LVL : WARN_LVL + 1;
    localparam int PASS_MIN = PASS_LVL + 1;
    localparam logic [CNT_W:0] WARN_MIN_V = WARN_MIN[CNT_W:0];
    localparam logic [CNT_W:0] PASS_MIN_V = PASS_MIN[CNT_W:0];

    lvl_e    state_q, state_d, target;
    lvl_tr_e tr;

    always_comb begin
        if ({1'b0, cnt_d} >= PASS_MIN_V) begin
            target = LV_PASS;
        end else if ({1'b0, cnt_d} >= WARN_MIN_V) begin
            target = LV_WARN;
        end else begin
            target = LV_OK;
        end
    end

    always_comb begin
        tr = TR_HOLD;
        unique case (state_q)
            LV_OK: begin
                if (target == LV_WARN)      tr = TR_OK_TO_WARN;
                else if (target == LV_PASS) tr = TR_OK_TO_PASS;
            end
            LV_WARN: begin
                if (target == LV_PASS)      tr = TR_WARN_TO_PASS;
                else if (target == LV_OK)   tr = TR_WARN_TO_OK;
            end
            LV_PASS: begin
                if (target == LV_WARN)      tr = TR_PASS_TO_WARN;
                else if (target == LV_OK)   tr = TR_PASS_TO_OK;
            end
            default: tr = TR_HOLD;
        endcase
    end

    always_comb begin
        unique case (tr)
            TR_OK_TO_WARN, TR_PASS_TO_WARN: state_d = LV_WARN;
            TR_OK_TO_PASS, TR_WARN_TO_PASS: state_d = LV_PASS;
            TR_WARN_TO_OK, TR_PASS_TO_OK:   state_d = LV_OK;
            default:                        state_d = state_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LV_OK;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        rise_o = (tr == TR_OK_TO_WARN) || (tr == TR_OK_TO_PASS) ||
                 (tr == TR_WARN_TO_PASS);
        unique case (state_q)
            LV_OK:   begin warn_o = 1'b0; pass_o = 1'b0; end
            LV_WARN: begin warn_o = 1'b1; pass_o = 1'b0; end
            LV_PASS: begin warn_o = 1'b1; pass_o = 1'b1; end
            default: begin warn_o = 1'b0; pass_o = 1'b0; end
        endcase
    end

    // R6: the passive state only exists above the passive limit
    a_r6_pass_above: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LV_PASS) |-> ({1'b0, cnt_q} >= PASS_MIN_V));
    // R4/R5: the clean state only exists below the warning limit
    a_r4_ok_below: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LV_OK) |-> ({1'b0, cnt_q} < WARN_MIN_V));
    a_r8_rise_moves_up: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> (state_q != LV_OK));

endmodule

// File: rtl/errflag_reg.sv
module errflag_reg (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rise_i,
    input  logic       ovr_i,
    input  logic       bad_i,
    input  logic [2:0] clr_i,
    input  logic       en_i,
    output logic       ovr_q,
    output logic       bad_q,
    output logic       err_q,
    output logic       irq_o
);
    logic set_err;

    assign set_err = rise_i | ovr_i | bad_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovr_q <= 1'b0;
            bad_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            if (ovr_i)         ovr_q <= 1'b1;
            else if (clr_i[1]) ovr_q <= 1'b0;
            if (bad_i)         bad_q <= 1'b1;
            else if (clr_i[2]) bad_q <= 1'b0;
            if (set_err)       err_q <= 1'b1;
            else if (clr_i[0]) err_q <= 1'b0;
        end
    end

    assign irq_o = err_q & en_i;

    a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i || ovr_i || bad_i) |=> err_q);
    a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !clr_i[0]) |=> err_q);
    a_r7_ovr_sets: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_i |=> ovr_q);
    a_r7_bad_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i[2] && !bad_i) |=> !bad_q);

endmodule

// File: rtl/can_errstat.sv
module can_errstat
    import can_errstat_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int WARN_LVL = 96,
    parameter int PASS_LVL = 127
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_ack_err_i,
    input  logic             tx_form_err_i,
    input  logic             tx_bit_err_i,
    input  logic             tx_done_i,
    input  logic             rx_err_i,
    input  logic             rx_done_i,
    input  logic             rx_ovr_i,
    input  logic             rx_bad_i,
    input  logic             irq_en_i,
    input  logic [2:0]       flag_clr_i,
    output logic [CNT_W-1:0] tx_cnt_o,
    output logic [CNT_W-1:0] rx_cnt_o,
    output logic             tx_warn_o,
    output logic             tx_pass_o,
    output logic             rx_warn_o,
    output logic             rx_pass_o,
    output logic             ovr_flag_o,
    output logic             bad_flag_o,
    output logic             err_flag_o,
    output logic             irq_o
);
    localparam int TX_INC_W = 2;

    logic [TX_INC_W-1:0] tx_inc;
    logic [CNT_W-1:0]    tx_cnt_d, rx_cnt_d;
    logic                tx_rise, rx_rise;

    assign tx_inc = {1'b0, tx_ack_err_i} + {1'b0, tx_form_err_i} +
                    {1'b0, tx_bit_err_i};

    errcnt_core #(.CNT_W(CNT_W), .INC_W(TX_INC_W)) u_tx_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (tx_inc),
        .dec_i (tx_done_i),
        .cnt_q (tx_cnt_o),
        .cnt_d (tx_cnt_d)
    );

    errcnt_core #(.CNT_W(CNT_W), .INC_W(1)) u_rx_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (rx_err_i),
        .dec_i (rx_done_i),
        .cnt_q (rx_cnt_o),
        .cnt_d (rx_cnt_d)
    );

    errlvl_fsm #(.CNT_W(CNT_W), .WARN_LVL(WARN_LVL), .PASS_LVL(PASS_LVL),
                 .WARN_INCL(1'b0)) u_tx_lvl (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_q  (tx_cnt_o),
        .cnt_d  (tx_cnt_d),
        .warn_o (tx_warn_o),
        .pass_o (tx_pass_o),
        .rise_o (tx_rise)
    );

    errlvl_fsm #(.CNT_W(CNT_W), .WARN_LVL(WARN_LVL), .PASS_LVL(PASS_LVL),
                 .WARN_INCL(1'b1)) u_rx_lvl (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_q  (rx_cnt_o),
        .cnt_d  (rx_cnt_d),
        .warn_o (rx_warn_o),
        .pass_o (rx_pass_o),
        .rise_o (rx_rise)
    );

    errflag_reg u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .rise_i (tx_rise | rx_rise),
        .ovr_i  (rx_ovr_i),
        .bad_i  (rx_bad_i),
        .clr_i  (flag_clr_i),
        .en_i   (irq_en_i),
        .ovr_q  (ovr_flag_o),
        .bad_q  (bad_flag_o),
        .err_q  (err_flag_o),
        .irq_o  (irq_o)
    );

    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (irq_en_i && err_flag_o));
    a_r6_pass_implies_warn: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_pass_o |-> tx_warn_o) and (rx_pass_o |-> rx_warn_o));

endmodule

// File: tb/sim_can_errstat.sv
module sim_can_errstat;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_ack_err_i = 1'b0, tx_form_err_i = 1'b0, tx_bit_err_i = 1'b0;
    logic       tx_done_i = 1'b0, rx_err_i = 1'b0, rx_done_i = 1'b0;
    logic       rx_ovr_i = 1'b0, rx_bad_i = 1'b0, irq_en_i = 1'b0;
    logic [2:0] flag_clr_i = 3'b000;
    logic [7:0] tx_cnt_o, rx_cnt_o;
    logic       tx_warn_o, tx_pass_o, rx_warn_o, rx_pass_o;
    logic       ovr_flag_o, bad_flag_o, err_flag_o, irq_o;

    int checks = 0;
    int errors = 0;
    int tx_m = 0, rx_m = 0;
    bit ovr_m = 0, bad_m = 0, err_m = 0;
    bit done = 0;

    always #10 clk = ~clk;

    can_errstat u0 (.*);

    function automatic int lvl_tx(input int c);
        return (c > 127) ? 2 : (c > 96) ? 1 : 0;
    endfunction
    function automatic int lvl_rx(input int c);
        return (c > 127) ? 2 : (c >= 96) ? 1 : 0;
    endfunction
    function automatic int clampc(input int c);
        return (c < 0) ? 0 : (c > 255) ? 255 : c;
    endfunction

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "tx_cnt", int'(tx_cnt_o), tx_m);
        chk(req, "rx_cnt", int'(rx_cnt_o), rx_m);
        chk("R4", "tx_warn", int'(tx_warn_o), int'(tx_m > 96));
        chk("R5", "rx_warn", int'(rx_warn_o), int'(rx_m >= 96));
        chk("R6", "tx_pass", int'(tx_pass_o), int'(tx_m > 127));
        chk("R6", "rx_pass", int'(rx_pass_o), int'(rx_m > 127));
        chk("R7", "ovr_flag", int'(ovr_flag_o), int'(ovr_m));
        chk("R7", "bad_flag", int'(bad_flag_o), int'(bad_m));
        chk("R8", "err_flag", int'(err_flag_o), int'(err_m));
        chk("R9", "irq", int'(irq_o), int'(err_m & irq_en_i));
    endtask

    // Called at a falling edge; applies one cycle of stimulus and checks after it.
    task automatic step(input logic [2:0] txe, input logic txo, input logic rxe,
                        input logic rxo, input logic ov, input logic bd,
                        input logic [2:0] clr, input string req);
        int otx, orx, ntx, nrx;
        bit rise;
        {tx_bit_err_i, tx_form_err_i, tx_ack_err_i} = txe;
        tx_done_i = txo; rx_err_i = rxe; rx_done_i = rxo;
        rx_ovr_i = ov; rx_bad_i = bd; flag_clr_i = clr;
        @(negedge clk);
        {tx_bit_err_i, tx_form_err_i, tx_ack_err_i} = 3'b000;
        tx_done_i = 0; rx_err_i = 0; rx_done_i = 0;
        rx_ovr_i = 0; rx_bad_i = 0; flag_clr_i = 3'b000;
        otx = lvl_tx(tx_m); orx = lvl_rx(rx_m);
        tx_m = clampc(tx_m + int'(txe[0]) + int'(txe[1]) + int'(txe[2]) - int'(txo));
        rx_m = clampc(rx_m + int'(rxe) - int'(rxo));
        ntx = lvl_tx(tx_m); nrx = lvl_rx(rx_m);
        rise = (ntx > otx) || (nrx > orx);
        if (ov) ovr_m = 1; else if (clr[1]) ovr_m = 0;
        if (bd) bad_m = 1; else if (clr[2]) bad_m = 0;
        if (rise || ov || bd) err_m = 1; else if (clr[0]) err_m = 0;
        check_all(req);
    endtask

    task automatic t_reset();
        // R1: everything zero out of reset
        chk("R1", "tx_cnt", int'(tx_cnt_o), 0);
        chk("R1", "rx_cnt", int'(rx_cnt_o), 0);
        chk("R1", "flags", int'({tx_warn_o, tx_pass_o, rx_warn_o, rx_pass_o,
                                 ovr_flag_o, bad_flag_o, err_flag_o, irq_o}), 0);
    endtask

    task automatic t_tx_count();
        step(3'b001, 0, 0, 0, 0, 0, 3'b000, "R2");
        step(3'b010, 0, 0, 0, 0, 0, 3'b000, "R2");
        step(3'b100, 0, 0, 0, 0, 0, 3'b000, "R2");
        chk("R2", "single faults", int'(tx_cnt_o), 3);
        step(3'b111, 0, 0, 0, 0, 0, 3'b000, "R2");
        chk("R2", "triple fault", int'(tx_cnt_o), 6);
        for (int i = 0; i < 7; i++) step(3'b000, 1, 0, 0, 0, 0, 3'b000, "R3");
        chk("R3", "tx floor", int'(tx_cnt_o), 0);
        step(3'b000, 0, 0, 1, 0, 0, 3'b000, "R3");
        chk("R3", "rx floor", int'(rx_cnt_o), 0);
    endtask

    task automatic t_tx_warn();
        for (int i = 0; i < 32; i++) step(3'b111, 0, 0, 0, 0, 0, 3'b000, "R2");
        chk("R4", "warn off at 96", int'(tx_warn_o), 0);
        step(3'b001, 0, 0, 0, 0, 0, 3'b000, "R4");
        chk("R4", "warn on at 97", int'(tx_warn_o), 1);
        chk("R8", "err on warn entry", int'(err_flag_o), 1);
        chk("R9", "irq masked", int'(irq_o), 0);
        irq_en_i = 1'b1;
        #1;
        chk("R9", "irq enabled", int'(irq_o), 1);
        step(3'b000, 0, 0, 0, 0, 0, 3'b001, "R8");
        chk("R8", "err cleared", int'(err_flag_o), 0);
        step(3'b000, 1, 0, 0, 0, 0, 3'b000, "R4");
        chk("R4", "warn off back at 96", int'(tx_warn_o), 0);
    endtask

    task automatic t_tx_pass_sat();
        for (int i = 0; i < 10; i++) step(3'b111, 0, 0, 0, 0, 0, 3'b000, "R2");
        step(3'b011, 0, 0, 0, 0, 0, 3'b000, "R6");
        chk("R6", "tx pass at 128", int'(tx_pass_o), 1);
        step(3'b000, 0, 0, 0, 0, 0, 3'b001, "R8");
        for (int i = 0; i < 43; i++) step(3'b111, 0, 0, 0, 0, 0, 3'b000, "R3");
        chk("R3", "tx ceiling", int'(tx_cnt_o), 255);
        chk("R8", "no set while holding", int'(err_flag_o), 0);
        for (int i = 0; i < 128; i++) step(3'b000, 1, 0, 0, 0, 0, 3'b000, "R3");
        chk("R6", "tx pass off at 127", int'(tx_pass_o), 0);
        for (int i = 0; i < 127; i++) step(3'b000, 1, 0, 0, 0, 0, 3'b000, "R3");
    endtask

    task automatic t_rx_levels();
        for (int i = 0; i < 95; i++) step(3'b000, 0, 1, 0, 0, 0, 3'b000, "R2");
        chk("R5", "rx warn off at 95", int'(rx_warn_o), 0);
        step(3'b000, 0, 1, 0, 0, 0, 3'b000, "R5");
        chk("R5", "rx warn on at 96", int'(rx_warn_o), 1);
        step(3'b000, 0, 0, 0, 0, 0, 3'b001, "R8");
        for (int i = 0; i < 32; i++) step(3'b000, 0, 1, 0, 0, 0, 3'b000, "R6");
        chk("R6", "rx pass on at 128", int'(rx_pass_o), 1);
        chk("R8", "err on rx passive", int'(err_flag_o), 1);
        for (int i = 0; i < 128; i++) step(3'b000, 0, 1, 0, 0, 0, 3'b000, "R3");
        chk("R3", "rx ceiling", int'(rx_cnt_o), 255);
        for (int i = 0; i < 160; i++) step(3'b000, 0, 0, 1, 0, 0, 3'b000, "R5");
        chk("R5", "rx warn off at 95", int'(rx_warn_o), 0);
    endtask

    task automatic t_causes();
        step(3'b000, 0, 0, 0, 0, 0, 3'b001, "R8");
        step(3'b000, 0, 0, 0, 1, 0, 3'b000, "R7");
        chk("R7", "overrun set", int'(ovr_flag_o), 1);
        step(3'b000, 0, 0, 0, 0, 0, 3'b010, "R7");
        chk("R7", "overrun cleared, err kept", int'({ovr_flag_o, err_flag_o}), 1);
        step(3'b000, 0, 0, 0, 0, 1, 3'b001, "R8");
        chk("R8", "set wins over clear", int'(err_flag_o), 1);
        chk("R7", "invalid set", int'(bad_flag_o), 1);
        step(3'b000, 0, 0, 0, 0, 0, 3'b101, "R7");
        chk("R7", "all cleared", int'({bad_flag_o, err_flag_o, irq_o}), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_tx_count();
        t_tx_warn();
        t_tx_pass_sat();
        t_rx_levels();
        t_causes();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung expected done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule